// File: doc/BRIEF.md
# Configuration Cycle Address Translator

This block sits between an upstream request link and a PCI bus master. Each request describes one single-DWord configuration read or write by its cycle type, bus number, device number, function number, DWord register index and a write flag. The block decides how the request is served and builds the 32-bit address-phase word the bus master drives. The three outcomes are a local Type 0 cycle, a Type 1 cycle forwarded to a bridge further down, or a not-claimed response with no bus cycle.

Routing uses two plain control inputs, the secondary bus number and the subordinate bus number. An upstream Type 0 request always goes to the local bus. It selects one of two fixed device-select bits, or none. A Type 1 request addressed to the secondary bus is rewritten as a Type 0 cycle with a one-hot device-select bit in the upper half of the address. A Type 1 request addressed to a bus in the range above the secondary number, up to and including the subordinate number, is passed on as a Type 1 cycle. Every other Type 1 request is not claimed.

Both edges use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The result is registered and shown on the next cycle. It holds without change while `out_valid` is high and `out_ready` is low. `req_ready` stays low the whole time a result is held, so at most one request is in flight. The upstream side must therefore keep its request steady until it is taken.

Top module: `pcfg_addr_xlat`

## Requirements
- R1: After reset `out_valid` is 0 and `req_ready` is 1.
- R2: A request taken while `req_ready` is 1 appears with `out_valid` = 1 on the next cycle. While `out_valid` is 1 and `out_ready` is 0, all outputs hold and `req_ready` is 0. One cycle after the edge where `out_valid` and `out_ready` are both 1, `out_valid` is 0 and `req_ready` is 1.
- R3: For `req_type` = 0 (upstream Type 0), the bus number has no effect. The outputs are `out_claim` = 1 and `out_type1` = 0, with the address as follows. AD[14] is set only for device 30 and AD[15] only for device 31. Every other bit of AD[31:11] is 0. AD[10:8] carry the function, AD[7:2] carry the register index, and AD[1:0] = 00.
- R4: For `req_type` = 1 with bus equal to the secondary number, the outputs are `out_claim` = 1 and `out_type1` = 0. For a device n from 0 to 15, exactly bit AD[16+n] is set within AD[31:16].
- R5: In the conversion of R4, a device number from 16 to 31 leaves AD[31:16] all 0.
- R6: In the conversion of R4, AD[15:11] are 0, AD[10:8] carry the function, AD[7:2] carry the register index, and AD[1:0] = 00.
- R7: For `req_type` = 1 with secondary < bus <= subordinate, the outputs are `out_claim` = 1 and `out_type1` = 1. The address is AD[31:24] = 0, AD[23:16] = bus, AD[15:11] = device, AD[10:8] = function, AD[7:2] = register and AD[1:0] = 01.
- R8: For `req_type` = 1 with bus below the secondary number or above the subordinate number, the outputs are `out_claim` = 0, `out_type1` = 0 and `out_addr` = 0. `out_valid` still rises so the response is delivered.
- R9: `out_wr` equals the write flag of the request being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_bus | input | 8 | Secondary bus number |
| sub_bus | input | 8 | Subordinate bus number |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_type | input | 1 | 0 = Type 0 request, 1 = Type 1 request |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_reg | input | 6 | DWord register index |
| req_wr | input | 1 | 1 = write, 0 = read |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_addr | output | 32 | Address-phase word |
| out_claim | output | 1 | 1 = bus cycle to run, 0 = not claimed |
| out_type1 | output | 1 | 1 = Type 1 cycle, 0 = Type 0 cycle |
| out_wr | output | 1 | Write flag of the result |

## Verification
The assertions assume the following about the inputs. The request fields are stable on the edge where they are taken. `sec_bus` and `sub_bus` do not change while a result is held, because the output checks compare the held word against the routing that was in force when the request was taken. The stimulus changes the bus registers only between transactions, while `out_valid` is 0. It drives every input half a cycle away from the active edge. During a hold it changes the request fields on purpose, to show they have no effect until the result is taken.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  localparam int ADDR_W = 32;
  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FN_W   = 3;
  localparam int REG_W  = 6;
  localparam int IDSEL_LO = 16;
  localparam int IDSEL_N  = ADDR_W - IDSEL_LO;

  typedef enum logic [1:0] {
    RT_LOCAL0 = 2'd0,
    RT_CONV   = 2'd1,
    RT_FWD1   = 2'd2,
    RT_REJECT = 2'd3
  } route_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              claim;
    logic              type1;
    logic              wr;
  } result_t;
endpackage

// File: rtl/pcfg_route.sv
module pcfg_route
  import pcfg_pkg::*;
(
  input  logic             is_type1,
  input  logic [BUS_W-1:0] bus,
  input  logic [BUS_W-1:0] sec_bus,
  input  logic [BUS_W-1:0] sub_bus,
  output route_e           route
);
  logic hit_sec;
  logic in_down;

  assign hit_sec = (bus == sec_bus);
  assign in_down = (bus > sec_bus) && (bus <= sub_bus);

  always_comb begin
    if (!is_type1)    route = RT_LOCAL0;
    else if (hit_sec) route = RT_CONV;
    else if (in_down) route = RT_FWD1;
    else              route = RT_REJECT;
  end
endmodule

// File: rtl/pcfg_addr_build.sv
module pcfg_addr_build
  import pcfg_pkg::*;
(
  input  route_e            route,
  input  logic [BUS_W-1:0]  bus,
  input  logic [DEV_W-1:0]  dev,
  input  logic [FN_W-1:0]   fn,
  input  logic [REG_W-1:0]  regi,
  output logic [ADDR_W-1:0] addr
);
  localparam int LOW_W = FN_W + REG_W;
  localparam int TOP_PAD = ADDR_W - IDSEL_LO - BUS_W;

  logic [IDSEL_N-1:0] idsel;
  logic [DEV_W-1:0]   up0_sel;
  logic [LOW_W-1:0]   low_fields;

  genvar gi;
  generate
    for (gi = 0; gi < IDSEL_N; gi++) begin : g_idsel
      assign idsel[gi] = (dev == DEV_W'(gi));
    end
  endgenerate

  assign up0_sel    = {dev == 5'd31, dev == 5'd30, 3'b000};
  assign low_fields = {fn, regi};

  always_comb begin
    unique case (route)
      RT_LOCAL0: addr = {{IDSEL_N{1'b0}}, up0_sel, low_fields, 2'b00};
      RT_CONV:   addr = {idsel, {DEV_W{1'b0}}, low_fields, 2'b00};
      RT_FWD1:   addr = {{TOP_PAD{1'b0}}, bus, dev, low_fields, 2'b01};
      default:   addr = '0;
    endcase
  end

  always_comb begin
    if (route == RT_CONV)
      assert ($onehot0(addr[ADDR_W-1:IDSEL_LO]))
        else $error("p_conv_onehot_r4: idsel not one-hot");
  end
endmodule

// File: rtl/pcfg_out_stage.sv
module pcfg_out_stage
  import pcfg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    take,
  input  result_t next,
  input  logic    out_ready,
  output logic    out_valid,
  output result_t held
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      held      <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      held      <= next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(held));
  p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid);
  p_no_take_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !take);
endmodule

// File: rtl/pcfg_addr_xlat.sv
module pcfg_addr_xlat
  import pcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  sec_bus,
  input  logic [BUS_W-1:0]  sub_bus,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_type,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FN_W-1:0]   req_fn,
  input  logic [REG_W-1:0]  req_reg,
  input  logic              req_wr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_claim,
  output logic              out_type1,
  output logic              out_wr
);
  route_e  route;
  result_t next;
  result_t held;
  logic    take;

  pcfg_route u_route (
    .is_type1 (req_type),
    .bus      (req_bus),
    .sec_bus  (sec_bus),
    .sub_bus  (sub_bus),
    .route    (route)
  );

  pcfg_addr_build u_build (
    .route (route),
    .bus   (req_bus),
    .dev   (req_dev),
    .fn    (req_fn),
    .regi  (req_reg),
    .addr  (next.addr)
  );

  assign next.claim = (route != RT_REJECT);
  assign next.type1 = (route == RT_FWD1);
  assign next.wr    = req_wr;

  assign req_ready = !out_valid;
  assign take      = req_valid && req_ready;

  pcfg_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .next      (next),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .held      (held)
  );

  assign out_addr  = held.addr;
  assign out_claim = held.claim;
  assign out_type1 = held.type1;
  assign out_wr    = held.wr;

  p_fwd_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_type1 |-> out_claim && out_addr[1:0] == 2'b01);
  p_reject_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_claim |-> out_addr == '0 && !out_type1);
  p_type0_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_claim && !out_type1 |->
      out_addr[1:0] == 2'b00 && $onehot0(out_addr[ADDR_W-1:11]));
  p_type1_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_type1 |->
      out_addr[23:16] > sec_bus && out_addr[23:16] <= sub_bus);
endmodule

// File: tb/tb_pcfg_addr_xlat.sv
`timescale 1ns/1ps
module tb_pcfg_addr_xlat;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  sec_bus = 8'h05;
  logic [7:0]  sub_bus = 8'h09;
  logic        req_valid = 0;
  logic        req_ready;
  logic        req_type = 0;
  logic [7:0]  req_bus = 0;
  logic [4:0]  req_dev = 0;
  logic [2:0]  req_fn = 0;
  logic [5:0]  req_reg = 0;
  logic        req_wr = 0;
  logic        out_valid;
  logic        out_ready = 0;
  logic [31:0] out_addr;
  logic        out_claim;
  logic        out_type1;
  logic        out_wr;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pcfg_addr_xlat dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected results computed from the requirements.
  function automatic logic [34:0] model(input logic t, input logic [7:0] b, input logic [4:0] d,
                                        input logic [2:0] f, input logic [5:0] r, input logic w);
    logic [31:0] a;
    logic cl, t1;
    a = 0; cl = 1; t1 = 0;
    if (!t) begin
      if (d == 30) a[14] = 1;
      if (d == 31) a[15] = 1;
      a[10:8] = f; a[7:2] = r;
    end else if (b == sec_bus) begin
      if (d < 16) a[16 + d] = 1;
      a[10:8] = f; a[7:2] = r;
    end else if (b > sec_bus && b <= sub_bus) begin
      t1 = 1; a[23:16] = b; a[15:11] = d; a[10:8] = f; a[7:2] = r; a[1:0] = 2'b01;
    end else begin
      cl = 0;
    end
    return {cl, t1, w, a};
  endfunction

  // Issue one request, check result, then drain it.
  task automatic xact(input string tag, input logic t, input logic [7:0] b, input logic [4:0] d,
                      input logic [2:0] f, input logic [5:0] r, input logic w);
    logic [34:0] e;
    e = model(t, b, d, f, r, w);
    @(negedge clk);
    req_valid = 1; req_type = t; req_bus = b; req_dev = d; req_fn = f; req_reg = r; req_wr = w;
    @(negedge clk);
    req_valid = 0;
    chk(out_valid === 1'b1, {tag, " valid"}, {31'b0, out_valid}, 32'd1);
    chk(out_addr === e[31:0], {tag, " addr"}, out_addr, e[31:0]);
    chk({out_claim, out_type1} === e[34:33], {tag, " flags"}, {30'b0, out_claim, out_type1}, {30'b0, e[34:33]});
    chk(out_wr === e[32], "R9 wr", {31'b0, out_wr}, {31'b0, e[32]});
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk(out_valid === 1'b0 && req_ready === 1'b1, "R2 drained", {30'b0, out_valid, req_ready}, 32'd1);
  endtask

  task automatic t_reset;
    chk(out_valid === 1'b0, "R1 out_valid", {31'b0, out_valid}, 0);
    chk(req_ready === 1'b1, "R1 req_ready", {31'b0, req_ready}, 1);
  endtask

  task automatic t_type0;
    xact("R3 dev30", 0, 8'h33, 30, 3'd2, 6'h11, 0);
    xact("R3 dev31", 0, 8'h00, 31, 3'd7, 6'h3f, 1);
    xact("R3 dev5", 0, 8'h05, 5, 3'd1, 6'h01, 0);
    xact("R3 dev29", 0, 8'hff, 29, 3'd0, 6'h20, 1);
  endtask

  task automatic t_conv;
    xact("R4 dev0", 1, 8'h05, 0, 3'd3, 6'h2a, 0);
    xact("R4 dev15", 1, 8'h05, 15, 3'd5, 6'h15, 1);
    xact("R4 dev7", 1, 8'h05, 7, 3'd7, 6'h3f, 0);
    xact("R5 dev16", 1, 8'h05, 16, 3'd1, 6'h02, 0);
    xact("R5 dev31", 1, 8'h05, 31, 3'd6, 6'h33, 1);
    xact("R6 fields", 1, 8'h05, 3, 3'd4, 6'h0c, 0);
  endtask

  task automatic t_fwd;
    xact("R7 low edge", 1, 8'h06, 9, 3'd2, 6'h04, 0);
    xact("R7 high edge", 1, 8'h09, 31, 3'd7, 6'h3f, 1);
    xact("R7 mid", 1, 8'h07, 0, 3'd0, 6'h00, 0);
  endtask

  task automatic t_reject;
    xact("R8 below", 1, 8'h04, 2, 3'd1, 6'h05, 0);
    xact("R8 above", 1, 8'h0a, 2, 3'd1, 6'h05, 1);
    xact("R8 zero", 1, 8'h00, 0, 3'd0, 6'h01, 0);
  endtask

  task automatic t_regs_change;
    sec_bus = 8'h20; sub_bus = 8'h20;
    xact("R4 newsec", 1, 8'h20, 12, 3'd0, 6'h08, 0);
    xact("R8 sub eq sec", 1, 8'h21, 12, 3'd0, 6'h08, 0);
    sec_bus = 8'h05; sub_bus = 8'h09;
  endtask

  task automatic t_hold;
    logic [34:0] e;
    e = model(1, 8'h08, 4, 3'd3, 6'h10, 1);
    @(negedge clk);
    req_valid = 1; req_type = 1; req_bus = 8'h08; req_dev = 4; req_fn = 3; req_reg = 6'h10; req_wr = 1;
    @(negedge clk);
    // keep valid high with different fields; must not be taken
    req_type = 0; req_bus = 8'h05; req_dev = 30; req_fn = 0; req_reg = 0; req_wr = 0;
    for (int i = 0; i < 4; i++) begin
      chk(out_valid === 1'b1 && req_ready === 1'b0, "R2 hold hs", {30'b0, out_valid, req_ready}, 32'd2);
      chk(out_addr === e[31:0], "R2 hold addr", out_addr, e[31:0]);
      chk(out_wr === 1'b1 && out_type1 === 1'b1, "R2 hold flags", {30'b0, out_wr, out_type1}, 32'd3);
      @(negedge clk);
    end
    req_valid = 0;
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk(out_valid === 1'b0, "R2 release", {31'b0, out_valid}, 0);
    @(negedge clk);
    chk(out_valid === 1'b0, "R2 no stray take", {31'b0, out_valid}, 0);
  endtask

  initial begin
    #500000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_type0();
    t_conv();
    t_fwd();
    t_reject();
    t_regs_change();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule